// File: doc/BRIEF.md
# DC-Balanced Video and Control Word Serializer

This block turns a parallel stream of video pixels and control bits into one serial bit stream. It runs on a bit clock and divides it by 20 to make the parallel-rate clock, which it drives out to the data source. On every rising edge of that parallel clock it captures either an 18-bit video value or a 9-bit control value. The data-enable input picks which one. Each captured value becomes one 20-bit serial word, and the word is shifted out least significant bit first, so the bit rate is twenty times the parallel rate.

Video words carry a type flag and an inversion flag. The 18 symbol bits are inverted when that keeps the running disparity of the line from growing. Control words carry the type flag and three copies of each of the five low control bits, so a receiver can vote across the copies. The upper four control bits go once each. The block holds the data-enable input back by two parallel cycles, which lets it see each phase change before it arrives. Around every change it sends two fixed transition words in place of control words. A strobe marks the bit time in which bit 0 of each word is on the serial output.

Top module: `dcb_word_serializer`

## Requirements
- R1: While reset is held, serial_o and word_start_o are 0 and par_clk_o is 1.
- R2: par_clk_o has a period of 20 bit clocks and is high for the first 10 of them. Inputs are captured on the bit-clock edge where par_clk_o rises.
- R3: When a captured frame has de_in = 1, its word has bit 0 = 1 (type flag), bit 1 = inversion flag, and bits 2..19 = the 18 video bits, each inverted when the flag is 1.
- R4: The symbols are inverted exactly when the running disparity and the symbol disparity (2 x ones - 18) are both positive or both negative. After every word, the running disparity gains 2 x ones(word) - 20 and is clamped to the range -127..+127. It starts at 0 after reset.
- R5: When a frame has de_in = 0 and no transition applies, its word has bit 0 = 0. Control bit k (k = 0..4) fills bits 3k+1..3k+3. Control bit k (k = 5..8) fills bit k+11.
- R6: A de_in = 0 frame that comes one or two frames before a de_in = 1 frame is sent as 20'h03F03. This takes priority over R7.
- R7: A de_in = 0 frame that comes one or two frames after a de_in = 1 frame is sent as 20'hFC0FC.
- R8: Words go out least significant bit first, one bit per bit clock. word_start_o is high only in the bit time that carries bit 0.
- R9: Bit 0 of the word for a frame appears right after the third parallel-clock rising edge that follows its capture. The first word_start_o comes 20 bit clocks after reset is released.
- R10: ctrl_in has no effect on a video word, and video_in has no effect on control or transition words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| de_in | input | 1 | Data enable: 1 selects video, 0 selects control |
| video_in | input | 18 | Video bits |
| ctrl_in | input | 9 | Control bits |
| par_clk_o | output | 1 | Parallel clock, bit clock divided by 20 |
| word_start_o | output | 1 | High in the bit time that carries bit 0 of a word |
| serial_o | output | 1 | Serial data, least significant bit first |

## Verification
Each captured frame takes three parallel periods to pass through the capture pipe. It then goes out over the next 20 bit clocks. The word for capture k therefore starts 3 x 20 bit clocks after that capture edge, and the first strobe comes exactly 20 bit clocks after reset is released. The driver changes the inputs on the falling bit-clock edge where word_start_o is high, then holds them for 20 bit clocks. Each value is captured by the next par_clk_o rise, 19.5 bit clocks later. The driver pushes the expected word into the scoreboard queue one slot per frame. The expected words, running disparity included, come from a frame model that covers the two-frame lookahead and history. The monitor assembles 20 bits on falling edges, starting at each strobe, and pops one expected word per strobe. It also counts the par_clk_o high time within that window.

// File: rtl/dcb_ser_pkg.sv
// Shared types for the DC-balanced word serializer.
package dcb_ser_pkg;
    // Kind of word chosen for one parallel frame
    typedef enum logic [1:0] {
        WK_CTRL  = 2'd0,
        WK_VIDEO = 2'd1,
        WK_PRE   = 2'd2,
        WK_POST  = 2'd3
    } word_kind_e;
endpackage

// File: rtl/dcb_frame_timer.sv
// Frame timer: divides the bit clock by DIV to make the parallel clock.
// It produces the capture/load tick and the word-start strobe.
// Assumes DIV >= 2. The tick is high in the last bit time of each frame.
module dcb_frame_timer #(
    parameter int DIV = 20
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick,
    output logic par_clk,
    output logic word_start
);
    localparam int CW = $clog2(DIV);

    logic [CW-1:0] cnt_q;
    logic          ws_q;

    // Bit position counter within the current frame
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (cnt_q == CW'(DIV - 1))
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    // Strobe that marks the bit time carrying bit 0
    always_ff @(posedge clk) begin
        if (!rst_n)
            ws_q <= 1'b0;
        else
            ws_q <= tick;
    end

    assign tick       = (cnt_q == CW'(DIV - 1));
    assign par_clk    = (cnt_q < CW'(DIV / 2));
    assign word_start = ws_q;
endmodule

// File: rtl/dcb_input_pipe.sv
// Input pipe: captures data-enable and the selected payload on each tick.
// It delays them by GUARD frames and reports whether any of the GUARD
// newer frames or the GUARD older frames had data-enable set.
// Assumes VID_W > CTL_W and GUARD >= 1.
module dcb_input_pipe #(
    parameter int VID_W = 18,
    parameter int CTL_W = 9,
    parameter int GUARD = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             de_in,
    input  logic [VID_W-1:0] vid_in,
    input  logic [CTL_W-1:0] ctl_in,
    output logic             cur_de,
    output logic [VID_W-1:0] cur_pay,
    output logic             look_any,
    output logic             hist_any
);
    localparam int DEPTH = GUARD + 1;

    logic [GUARD:0]   st_de;
    logic [VID_W-1:0] st_pay [DEPTH];
    logic [GUARD-1:0] hist_q;
    logic [VID_W-1:0] cap_pay;

    // Select the payload that data-enable picks
    always_comb begin
        cap_pay = de_in ? vid_in : {{(VID_W - CTL_W){1'b0}}, ctl_in};
    end

    // Data-enable delay line, index 0 newest
    always_ff @(posedge clk) begin
        if (!rst_n)
            st_de <= '0;
        else if (tick)
            st_de <= {st_de[GUARD-1:0], de_in};
    end

    // Payload delay line, moves in step with data-enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) st_pay[i] <= '0;
        end else if (tick) begin
            st_pay[0] <= cap_pay;
            for (int i = 1; i < DEPTH; i++) st_pay[i] <= st_pay[i-1];
        end
    end

    // History of data-enable for frames already sent
    always_ff @(posedge clk) begin
        if (!rst_n)
            hist_q <= '0;
        else if (tick)
            hist_q <= (hist_q << 1) | GUARD'(st_de[GUARD]);
    end

    assign cur_de   = st_de[GUARD];
    assign cur_pay  = st_pay[GUARD];
    assign look_any = |st_de[GUARD-1:0];
    assign hist_any = |hist_q;
endmodule

// File: rtl/dcb_word_builder.sv
// Word builder: frames the current payload as a video, control or
// transition word. It applies the disparity-driven symbol inversion and
// keeps the clamped running disparity, which it updates on each tick.
// Assumes WORD_W = VID_W + 2 = 1 + 2*TRIPLE_N + CTL_W.
module dcb_word_builder
    import dcb_ser_pkg::*;
#(
    parameter int                  VID_W     = 18,
    parameter int                  CTL_W     = 9,
    parameter int                  TRIPLE_N  = 5,
    parameter int                  RD_MAX    = 127,
    parameter int                  WORD_W    = VID_W + 2,
    parameter int                  RD_W      = $clog2(RD_MAX + 1) + 1,
    parameter logic [WORD_W-1:0]   PRE_WORD  = 20'h03F03,
    parameter logic [WORD_W-1:0]   POST_WORD = 20'hFC0FC
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   tick,
    input  logic                   cur_de,
    input  logic [VID_W-1:0]       cur_pay,
    input  logic                   look_any,
    input  logic                   hist_any,
    output logic [WORD_W-1:0]      word,
    output word_kind_e             kind,
    output logic signed [RD_W-1:0] run_disp
);
    logic signed [RD_W-1:0] rd_q;
    logic [WORD_W-1:0]      ctl_word;
    logic [WORD_W-1:0]      vid_word;
    logic                   inv;
    int                     sym_disp;
    int                     word_disp;
    int                     rd_sum;

    // Control framing: type bit, triplicated low bits, single high bits
    assign ctl_word[0] = 1'b0;
    for (genvar k = 0; k < TRIPLE_N; k++) begin : g_triple
        assign ctl_word[1 + 3*k +: 3] = {3{cur_pay[k]}};
    end
    for (genvar k = TRIPLE_N; k < CTL_W; k++) begin : g_single
        assign ctl_word[1 + 2*TRIPLE_N + k] = cur_pay[k];
    end

    // Inversion decision and video framing
    always_comb begin
        sym_disp = 2 * $countones(cur_pay) - VID_W;
        inv      = ((rd_q > 0) && (sym_disp > 0)) || ((rd_q < 0) && (sym_disp < 0));
        vid_word = {(inv ? ~cur_pay : cur_pay), inv, 1'b1};
    end

    // Word kind: video first, then the pre-rise guard, then the post-fall guard
    always_comb begin
        if (cur_de)        kind = WK_VIDEO;
        else if (look_any) kind = WK_PRE;
        else if (hist_any) kind = WK_POST;
        else               kind = WK_CTRL;
    end

    // Word selection by kind
    always_comb begin
        case (kind)
            WK_VIDEO: word = vid_word;
            WK_PRE:   word = PRE_WORD;
            WK_POST:  word = POST_WORD;
            default:  word = ctl_word;
        endcase
    end

    // Next running disparity, clamped to +/- RD_MAX
    always_comb begin
        word_disp = 2 * $countones(word) - WORD_W;
        rd_sum    = int'(rd_q) + word_disp;
        if (rd_sum > RD_MAX)       rd_sum = RD_MAX;
        else if (rd_sum < -RD_MAX) rd_sum = -RD_MAX;
    end

    // Running disparity register, updated once per emitted word
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_q <= '0;
        else if (tick)
            rd_q <= RD_W'(rd_sum);
    end

    assign run_disp = rd_q;
endmodule

// File: rtl/dcb_shifter.sv
// Output shifter: loads a word on the tick and shifts it right once per
// bit clock, so the least significant bit leaves first.
module dcb_shifter #(
    parameter int WORD_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [WORD_W-1:0] word,
    output logic              serial
);
    logic [WORD_W-1:0] sreg_q;

    // Load on tick, otherwise shift toward bit 0
    always_ff @(posedge clk) begin
        if (!rst_n)
            sreg_q <= '0;
        else if (tick)
            sreg_q <= word;
        else
            sreg_q <= {1'b0, sreg_q[WORD_W-1:1]};
    end

    assign serial = sreg_q[0];
endmodule

// File: rtl/dcb_word_serializer.sv
// Top: DC-balanced video/control word serializer. Runs on the bit clock,
// makes the parallel clock by dividing it down, and delays data-enable by
// GUARD frames so that transition words can go ahead of each phase change.
module dcb_word_serializer
    import dcb_ser_pkg::*;
#(
    parameter int                  VID_W     = 18,
    parameter int                  CTL_W     = 9,
    parameter int                  TRIPLE_N  = 5,
    parameter int                  GUARD     = 2,
    parameter int                  RD_MAX    = 127,
    parameter logic [VID_W+1:0]    PRE_WORD  = 20'h03F03,
    parameter logic [VID_W+1:0]    POST_WORD = 20'hFC0FC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             de_in,
    input  logic [VID_W-1:0] video_in,
    input  logic [CTL_W-1:0] ctrl_in,
    output logic             par_clk_o,
    output logic             word_start_o,
    output logic             serial_o
);
    localparam int WORD_W = VID_W + 2;
    localparam int RD_W   = $clog2(RD_MAX + 1) + 1;

    logic                   tick;
    logic                   cur_de;
    logic [VID_W-1:0]       cur_pay;
    logic                   look_any;
    logic                   hist_any;
    logic [WORD_W-1:0]      word;
    word_kind_e             kind;
    logic signed [RD_W-1:0] run_disp;

    dcb_frame_timer #(.DIV(WORD_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .par_clk    (par_clk_o),
        .word_start (word_start_o)
    );

    dcb_input_pipe #(.VID_W(VID_W), .CTL_W(CTL_W), .GUARD(GUARD)) u_pipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .de_in    (de_in),
        .vid_in   (video_in),
        .ctl_in   (ctrl_in),
        .cur_de   (cur_de),
        .cur_pay  (cur_pay),
        .look_any (look_any),
        .hist_any (hist_any)
    );

    dcb_word_builder #(
        .VID_W     (VID_W),
        .CTL_W     (CTL_W),
        .TRIPLE_N  (TRIPLE_N),
        .RD_MAX    (RD_MAX),
        .WORD_W    (WORD_W),
        .RD_W      (RD_W),
        .PRE_WORD  (PRE_WORD),
        .POST_WORD (POST_WORD)
    ) u_build (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .cur_de   (cur_de),
        .cur_pay  (cur_pay),
        .look_any (look_any),
        .hist_any (hist_any),
        .word     (word),
        .kind     (kind),
        .run_disp (run_disp)
    );

    dcb_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .word   (word),
        .serial (serial_o)
    );
endmodule

// File: rtl/dcb_word_serializer_chk.sv
// Checker for the serializer, bound to the top. It relates the frame
// pipeline's choice of word to the first serial bit after each load.
module dcb_word_serializer_chk
    import dcb_ser_pkg::*;
#(
    parameter int RD_W   = 8,
    parameter int RD_MAX = 127
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   par_clk_o,
    input logic                   word_start_o,
    input logic                   serial_o,
    input logic                   tick,
    input logic                   cur_de,
    input word_kind_e             kind,
    input logic signed [RD_W-1:0] run_disp
);
    // R2
    par_rise_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(par_clk_o) |-> word_start_o);

    // R8
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_start_o |=> !word_start_o);

    // R3
    video_type_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cur_de) |=> serial_o);

    // R5
    ctrl_type_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && kind == WK_CTRL) |=> !serial_o);

    // R6
    pre_word_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && kind == WK_PRE) |=> serial_o);

    // R7
    post_word_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && kind == WK_POST) |=> !serial_o);

    // R4
    disp_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_disp <= RD_MAX) && (run_disp >= -RD_MAX));
endmodule

bind dcb_word_serializer dcb_word_serializer_chk #(.RD_W(RD_W), .RD_MAX(RD_MAX)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .par_clk_o    (par_clk_o),
    .word_start_o (word_start_o),
    .serial_o     (serial_o),
    .tick         (tick),
    .cur_de       (cur_de),
    .kind         (kind),
    .run_disp     (run_disp)
);

// File: tb/dcb_word_serializer_tb.sv
// Scoreboard bench: the driver pushes one expected word per frame and the
// monitor assembles serial words and compares them in order.
module dcb_word_serializer_tb;
    localparam int VW = 18;
    localparam int CW = 9;
    localparam int WW = 20;
    localparam int RDM = 127;
    localparam int MAXF = 64;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          de_in = 1'b0;
    logic [VW-1:0] video_in = '0;
    logic [CW-1:0] ctrl_in = '0;
    wire           par_clk_o;
    wire           word_start_o;
    wire           serial_o;

    dcb_word_serializer u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .de_in        (de_in),
        .video_in     (video_in),
        .ctrl_in      (ctrl_in),
        .par_clk_o    (par_clk_o),
        .word_start_o (word_start_o),
        .serial_o     (serial_o)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit reported = 1'b0;

    logic          f_de  [MAXF];
    logic [VW-1:0] f_vid [MAXF];
    logic [CW-1:0] f_ctl [MAXF];
    int            nf = 0;
    logic [WW-1:0] exp_w  [MAXF];
    string         exp_t  [MAXF];
    logic [WW-1:0] exp_q [$];
    string         tag_q [$];

    task automatic add_frame(input logic d, input logic [VW-1:0] v, input logic [CW-1:0] c);
        f_de[nf] = d; f_vid[nf] = v; f_ctl[nf] = c; nf++;
    endtask

    function automatic logic de_at(input int i);
        return (i >= 0 && i < nf) ? f_de[i] : 1'b0;
    endfunction

    // Reference frame model built from the requirements
    task automatic build_model();
        int rd;
        rd = 0;
        for (int i = 0; i < nf; i++) begin
            logic [WW-1:0] w;
            int d;
            logic inv;
            if (f_de[i]) begin
                d   = 2 * $countones(f_vid[i]) - VW;
                inv = (rd > 0 && d > 0) || (rd < 0 && d < 0);
                w   = {(inv ? ~f_vid[i] : f_vid[i]), inv, 1'b1};
                exp_t[i] = "R3 R4 R10 video";
            end else if (de_at(i + 1) || de_at(i + 2)) begin
                w = 20'h03F03;
                exp_t[i] = "R6 pre-rise";
            end else if (de_at(i - 1) || de_at(i - 2)) begin
                w = 20'hFC0FC;
                exp_t[i] = "R7 post-fall";
            end else begin
                w = '0;
                for (int k = 0; k < 5; k++) w[1 + 3*k +: 3] = {3{f_ctl[i][k]}};
                for (int k = 5; k < CW; k++) w[11 + k] = f_ctl[i][k];
                exp_t[i] = "R5 R10 control";
            end
            exp_w[i] = w;
            rd = rd + 2 * $countones(w) - WW;
            if (rd > RDM) rd = RDM;
            else if (rd < -RDM) rd = -RDM;
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Stimulus list, model and driver
    initial begin : driver
        for (int i = 0; i < 4; i++) add_frame(1'b0, '0, '0);
        add_frame(1'b0, 18'h2BEEF, 9'h1A5);
        add_frame(1'b0, 18'h2BEEF, 9'h0F3);
        add_frame(1'b0, 18'h2BEEF, 9'h10C);
        add_frame(1'b0, 18'h2BEEF, 9'h1FF);
        for (int i = 0; i < 8; i++) add_frame(1'b1, 18'h3FFFF, 9'h1FF);
        add_frame(1'b1, 18'h2A5C3, 9'h155);
        add_frame(1'b1, 18'h00000, 9'h0AA);
        add_frame(1'b1, 18'h1F0E1, 9'h1C7);
        add_frame(1'b0, 18'h2BEEF, 9'h1FF);
        add_frame(1'b1, 18'h0F0F0, 9'h000);
        add_frame(1'b1, 18'h3C3C3, 9'h1FF);
        add_frame(1'b0, 18'h12345, 9'h155);
        add_frame(1'b0, 18'h12345, 9'h0AA);
        add_frame(1'b0, 18'h3FFFF, 9'h1C7);
        add_frame(1'b0, 18'h3FFFF, 9'h038);
        add_frame(1'b0, 18'h00F00, 9'h1FF);
        add_frame(1'b0, 18'h00F00, 9'h101);
        add_frame(1'b0, 18'h00F00, 9'h0FE);
        add_frame(1'b1, 18'h12345, 9'h1FF);
        for (int i = 0; i < 4; i++) add_frame(1'b0, '0, 9'h1E0);
        build_model();
        for (int i = 0; i < 4; i++) begin
            exp_q.push_back(exp_w[i]);
            tag_q.push_back(exp_t[i]);
        end
        repeat (5) @(negedge clk);
        // R1: reset state
        checks++;
        if (serial_o !== 1'b0 || word_start_o !== 1'b0 || par_clk_o !== 1'b1) begin
            errors++;
            $display("FAIL R1: reset outputs actual ser=%b ws=%b pclk=%b expected 0 0 1",
                     serial_o, word_start_o, par_clk_o);
        end
        rst_n = 1'b1;
        do @(negedge clk); while (word_start_o !== 1'b1);
        for (int j = 4; j < nf; j++) begin
            de_in    = f_de[j];
            video_in = f_vid[j];
            ctrl_in  = f_ctl[j];
            exp_q.push_back(exp_w[j]);
            tag_q.push_back(exp_t[j]);
            repeat (WW) @(negedge clk);
        end
        de_in = 1'b0; video_in = '0; ctrl_in = 9'h1E0;
    end

    // Monitor: assembles serial words and compares them against the queue
    initial begin : monitor
        int wait_n;
        wait (rst_n === 1'b1);
        wait_n = 0;
        do begin
            @(negedge clk);
            wait_n++;
        end while (word_start_o !== 1'b1 && wait_n < 100);
        // R9: first strobe 20 bit clocks after reset release
        checks++;
        if (wait_n != WW) begin
            errors++;
            $display("FAIL R9: first word_start after %0d bit clocks expected %0d", wait_n, WW);
        end
        for (int n = 0; n < nf; n++) begin
            logic [WW-1:0] got;
            logic [WW-1:0] exp;
            string tag;
            int hi;
            bit strobe_ok;
            hi = 0;
            strobe_ok = 1'b1;
            for (int i = 0; i < WW; i++) begin
                if ((i == 0) != (word_start_o === 1'b1)) strobe_ok = 1'b0;
                got[i] = serial_o;
                if (par_clk_o === 1'b1) hi++;
                @(negedge clk);
            end
            exp = exp_q.pop_front();
            tag = tag_q.pop_front();
            // R8 R9: LSB-first assembly aligned to the strobe, fixed latency
            checks++;
            if (got !== exp) begin
                errors++;
                $display("FAIL %s (R8 R9) word %0d: actual %h expected %h", tag, n, got, exp);
            end
            // R8: strobe only in bit 0 time
            checks++;
            if (!strobe_ok) begin
                errors++;
                $display("FAIL R8: word %0d strobe pattern actual bad expected bit0 only", n);
            end
            // R2: parallel clock high for half of each frame
            checks++;
            if (hi != WW / 2) begin
                errors++;
                $display("FAIL R2: word %0d par_clk high %0d expected %0d", n, hi, WW / 2);
            end
        end
        done = 1'b1;
        report();
    end

    // Watchdog
    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        report();
    end
endmodule